// File: doc/BRIEF.md
# Dual-Processor Mailbox Port

This block lets two processors exchange bytes through one shared data port. The master sits on the system clock and uses a small synchronous register interface. It writes a byte into an outbound register, and it can read back three things: that register, the inbound byte the slave left, and a status word. The slave has no clock of its own here. It drives a chip select, a read strobe and a write strobe, all active low, and a data port.

The two directions keep their bytes in separate storage. When the slave selects the block and pulls its read strobe low, the port output enable goes high at once and the port carries the outbound byte. At every other time the enable is low, so the slave may drive the lines. When the slave selects the block and pulls its write strobe low, the port value is taken into the inbound cells as the write term ends. The slave strobes pass through a synchronizer before they update any flag or cell.

Each direction has a full flag. Writing a new byte sets the flag, and the other side reading that byte clears it. The master sees both flags in the status word.

Top module: `mailbox_port`

## Requirements
- R1: While reset is held, and after it is released, the outbound register, the inbound cells and both flags are zero, and `port_oe` is low.
- R2: A master write with `m_addr` = 0 loads `m_wdata` into the outbound register. The byte can be read back at address 0, and the write sets the outbound flag (status bit 0).
- R3: `port_oe` is high exactly while `slv_cs_n` and `slv_rd_n` are both low. `port_dout` shows the outbound register while `port_oe` is high and is zero otherwise.
- R4: A slave write (`slv_cs_n` and `slv_wr_n` both low) stores the `port_din` value present on its last active cycle into the inbound cells once the write term ends. The byte can be read at address 1, and the write sets the inbound flag (status bit 1).
- R5: A write strobe with `slv_cs_n` high changes neither the inbound cells nor the inbound flag.
- R6: A read strobe with `slv_cs_n` high leaves `port_oe` low and leaves the outbound flag set.
- R7: When a slave read ends, the outbound flag clears.
- R8: A master read (`m_rd_en`) at address 1 clears the inbound flag. Master reads at address 2 leave it unchanged.
- R9: A master write to an address other than 0 leaves the outbound register and the outbound flag unchanged.
- R10: The inbound cells keep their byte until the next slave write. Master reads do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_wr_en | input | 1 | Master write enable |
| m_rd_en | input | 1 | Master read enable, used for flag clearing |
| m_addr | input | 2 | 0 = outbound, 1 = inbound, 2 = status, 3 = reads zero |
| m_wdata | input | DATA_W | Master write data |
| m_rdata | output | DATA_W | Master read data, combinational from m_addr |
| slv_cs_n | input | 1 | Slave chip select, active low |
| slv_rd_n | input | 1 | Slave read strobe, active low |
| slv_wr_n | input | 1 | Slave write strobe, active low |
| port_din | input | DATA_W | Value the slave drives on the port |
| port_dout | output | DATA_W | Value the block drives on the port |
| port_oe | output | 1 | Port driver enable |

## Verification
The outbound path is tested with two different bytes, so a register that is stuck or that failed to load cannot pass. The slave strobes are tried three ways: with chip select low, with chip select high and the read strobe low, and with chip select high and the write strobe low. Only the first combination may reach storage or the driver. The bench changes `port_din` at the same moment the write term ends, so a capture that used the trailing data instead of the last active data would be caught. Master reads at the status address and at the inbound address are compared, which separates a flag clear tied to the correct address from one tied to any read.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   typedef enum logic [1:0] {
      MB_ADDR_OUTBOUND = 2'd0,
      MB_ADDR_INBOUND  = 2'd1,
      MB_ADDR_STATUS   = 2'd2,
      MB_ADDR_SPARE    = 2'd3
   } mb_addr_e;

   localparam int MB_STAT_OUT_BIT = 0;
   localparam int MB_STAT_IN_BIT  = 1;

endpackage

// File: rtl/mbox_strobe_decode.sv
module mbox_strobe_decode #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic rd_n,
   input  logic wr_n,
   output logic rd_act,
   output logic wr_act,
   output logic rd_done,
   output logic wr_done
);

   localparam int NSIG = 3;

   logic [NSIG-1:0] raw;
   logic [NSIG-1:0] syn;
   logic            rd_q;
   logic            wr_q;

   assign raw = {cs_n, rd_n, wr_n};

   generate
      if (STAGES == 0) begin : g_direct
         assign syn = raw;
      end else begin : g_sync
         logic [NSIG-1:0] chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain[i] <= '1;
            end else begin
               chain[0] <= raw;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign syn = chain[STAGES-1];
      end
   endgenerate

   assign rd_act = ~syn[2] & ~syn[1];
   assign wr_act = ~syn[2] & ~syn[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         wr_q <= 1'b0;
      end else begin
         rd_q <= rd_act;
         wr_q <= wr_act;
      end
   end

   assign rd_done = rd_q & ~rd_act;
   assign wr_done = wr_q & ~wr_act;

endmodule

// File: rtl/mbox_capture.sv
module mbox_capture #(
   parameter int DATA_W = 8,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              wr_act,
   input  logic              wr_done,
   output logic [DATA_W-1:0] cells
);

   logic [DATA_W-1:0] din_al;
   logic [DATA_W-1:0] hold;

   generate
      if (STAGES == 0) begin : g_direct
         assign din_al = din;
      end else begin : g_align
         logic [DATA_W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= din;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign din_al = pipe[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold  <= '0;
         cells <= '0;
      end else begin
         if (wr_act)  hold  <= din_al;
         if (wr_done) cells <= hold;
      end
   end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

endmodule

// File: rtl/mailbox_port.sv
module mailbox_port
   import mbox_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_wr_en,
   input  logic              m_rd_en,
   input  logic [1:0]        m_addr,
   input  logic [DATA_W-1:0] m_wdata,
   output logic [DATA_W-1:0] m_rdata,
   input  logic              slv_cs_n,
   input  logic              slv_rd_n,
   input  logic              slv_wr_n,
   input  logic [DATA_W-1:0] port_din,
   output logic [DATA_W-1:0] port_dout,
   output logic              port_oe
);

   localparam int STAT_BITS = 2;

   initial begin
      assert (DATA_W >= STAT_BITS)
         else $error("mailbox_port: DATA_W must hold the status bits");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("mailbox_port: SYNC_STAGES out of range");
   end

   mb_addr_e          addr_e;
   logic [DATA_W-1:0] out_q;
   logic [DATA_W-1:0] in_cells;
   logic              out_full;
   logic              in_full;
   logic              rd_act;
   logic              wr_act;
   logic              rd_done;
   logic              wr_done;
   logic              out_load;
   logic              in_take;

   assign addr_e = mb_addr_e'(m_addr);

   mbox_strobe_decode #(.STAGES(SYNC_STAGES)) strobe_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (slv_cs_n),
      .rd_n    (slv_rd_n),
      .wr_n    (slv_wr_n),
      .rd_act  (rd_act),
      .wr_act  (wr_act),
      .rd_done (rd_done),
      .wr_done (wr_done)
   );

   mbox_capture #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) capture_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (port_din),
      .wr_act  (wr_act),
      .wr_done (wr_done),
      .cells   (in_cells)
   );

   assign out_load = m_wr_en && (addr_e == MB_ADDR_OUTBOUND);
   assign in_take  = m_rd_en && (addr_e == MB_ADDR_INBOUND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        out_q <= '0;
      else if (out_load) out_q <= m_wdata;
   end

   mbox_flag out_flag_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (out_load),
      .clr   (rd_done),
      .q     (out_full)
   );

   mbox_flag in_flag_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (wr_done),
      .clr   (in_take),
      .q     (in_full)
   );

   // The driver enable comes straight from the pins, with no clock in the path.
   assign port_oe   = ~slv_cs_n & ~slv_rd_n;
   assign port_dout = port_oe ? out_q : '0;

   always_comb begin
      m_rdata = '0;
      unique case (addr_e)
         MB_ADDR_OUTBOUND: m_rdata = out_q;
         MB_ADDR_INBOUND:  m_rdata = in_cells;
         MB_ADDR_STATUS: begin
            m_rdata[MB_STAT_OUT_BIT] = out_full;
            m_rdata[MB_STAT_IN_BIT]  = in_full;
         end
         default:          m_rdata = '0;
      endcase
   end

   logic unused_act;
   assign unused_act = rd_act;

endmodule

// File: rtl/mailbox_port_chk.sv
module mailbox_port_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m_wr_en,
   input logic              m_rd_en,
   input logic [1:0]        m_addr,
   input logic [DATA_W-1:0] m_wdata,
   input logic [DATA_W-1:0] port_dout,
   input logic              port_oe,
   input logic [DATA_W-1:0] out_q,
   input logic [DATA_W-1:0] in_cells,
   input logic              out_full,
   input logic              in_full,
   input logic              rd_done,
   input logic              wr_done
);

   // R1
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (out_q == '0 && in_cells == '0 && !out_full && !in_full));

   // R2
   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wr_en && m_addr == 2'd0) |=> (out_q == $past(m_wdata) && out_full));

   // R3
   a_r3_quiet_port: assert property (@(posedge clk) disable iff (!rst_n)
      !port_oe |-> port_dout == '0);

   // R4
   a_r4_in_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> in_full);

   // R7
   a_r7_out_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && !(m_wr_en && m_addr == 2'd0)) |=> !out_full);

   // R8
   a_r8_in_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (m_rd_en && m_addr == 2'd1 && !wr_done) |=> !in_full);

   // R9
   a_r9_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wr_en && m_addr != 2'd0 && !rd_done) |=> ($stable(out_q) && $stable(out_full)));

   // R10
   a_r10_cells_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_done |=> $stable(in_cells));

endmodule

bind mailbox_port mailbox_port_chk #(.DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .m_wr_en   (m_wr_en),
   .m_rd_en   (m_rd_en),
   .m_addr    (m_addr),
   .m_wdata   (m_wdata),
   .port_dout (port_dout),
   .port_oe   (port_oe),
   .out_q     (out_q),
   .in_cells  (in_cells),
   .out_full  (out_full),
   .in_full   (in_full),
   .rd_done   (rd_done),
   .wr_done   (wr_done)
);

// File: tb/mailbox_port_tb_top.sv
`timescale 1ns/1ps
module mailbox_port_tb_top;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         m_wr_en = 1'b0;
   logic         m_rd_en = 1'b0;
   logic [1:0]   m_addr = 2'd0;
   logic [W-1:0] m_wdata = '0;
   logic [W-1:0] m_rdata;
   logic         slv_cs_n = 1'b1;
   logic         slv_rd_n = 1'b1;
   logic         slv_wr_n = 1'b1;
   logic [W-1:0] port_din = '0;
   logic [W-1:0] port_dout;
   logic         port_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   mailbox_port #(.DATA_W(W), .SYNC_STAGES(2)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .m_wr_en   (m_wr_en),
      .m_rd_en   (m_rd_en),
      .m_addr    (m_addr),
      .m_wdata   (m_wdata),
      .m_rdata   (m_rdata),
      .slv_cs_n  (slv_cs_n),
      .slv_rd_n  (slv_rd_n),
      .slv_wr_n  (slv_wr_n),
      .port_din  (port_din),
      .port_dout (port_dout),
      .port_oe   (port_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic peek(input logic [1:0] a, output logic [W-1:0] v);
      m_addr = a;
      #1 v = m_rdata;
   endtask

   task automatic master_write(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      m_addr = a; m_wdata = d; m_wr_en = 1'b1;
      @(negedge clk);
      m_wr_en = 1'b0;
   endtask

   task automatic master_read(input logic [1:0] a);
      @(negedge clk);
      m_addr = a; m_rd_en = 1'b1;
      @(negedge clk);
      m_rd_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      rst_n = 1'b0;
      idle(3);
      #1 check("R1 oe in reset", port_oe, 0);
      rst_n = 1'b1;
      idle(2);
      peek(2'd0, v); check("R1 outbound", v, 0);
      peek(2'd1, v); check("R1 inbound", v, 0);
      peek(2'd2, v); check("R1 status", v, 0);
      check("R1 dout", port_dout, 0);
   endtask

   task automatic t_master_write(input logic [W-1:0] d);
      logic [W-1:0] v;
      master_write(2'd0, d);
      peek(2'd0, v); check("R2 readback", v, d);
      peek(2'd2, v); check("R2 out flag", v[0], 1);
   endtask

   task automatic t_slave_read(input logic [W-1:0] d);
      logic [W-1:0] v;
      @(negedge clk);
      #1 check("R3 idle oe", port_oe, 0);
      check("R3 idle dout", port_dout, 0);
      slv_cs_n = 1'b0; slv_rd_n = 1'b0;
      #1 check("R3 oe", port_oe, 1);
      check("R3 dout", port_dout, d);
      idle(3);
      slv_rd_n = 1'b1; slv_cs_n = 1'b1;
      #1 check("R3 release oe", port_oe, 0);
      idle(6);
      peek(2'd2, v); check("R7 out flag cleared", v[0], 0);
   endtask

   task automatic t_read_no_cs();
      logic [W-1:0] v;
      @(negedge clk);
      slv_cs_n = 1'b1; slv_rd_n = 1'b0;
      #1 check("R6 oe stays low", port_oe, 0);
      idle(3);
      slv_rd_n = 1'b1;
      idle(6);
      peek(2'd2, v); check("R6 out flag kept", v[0], 1);
   endtask

   task automatic t_slave_write(input logic [W-1:0] d);
      logic [W-1:0] v;
      @(negedge clk);
      port_din = ~d; slv_cs_n = 1'b0; slv_wr_n = 1'b0;
      idle(2);
      port_din = d;
      idle(2);
      slv_wr_n = 1'b1; slv_cs_n = 1'b1; port_din = 8'h00;
      idle(7);
      peek(2'd1, v); check("R4 inbound byte", v, d);
      peek(2'd2, v); check("R4 in flag", v[1], 1);
   endtask

   task automatic t_master_read_clear(input logic [W-1:0] d);
      logic [W-1:0] v;
      master_read(2'd2);
      peek(2'd2, v); check("R8 status read keeps flag", v[1], 1);
      master_read(2'd1);
      peek(2'd2, v); check("R8 inbound read clears flag", v[1], 0);
      peek(2'd1, v); check("R10 cells kept after read", v, d);
   endtask

   task automatic t_write_no_cs(input logic [W-1:0] d);
      logic [W-1:0] v;
      @(negedge clk);
      port_din = 8'hE7; slv_cs_n = 1'b1; slv_wr_n = 1'b0;
      idle(4);
      slv_wr_n = 1'b1;
      idle(7);
      peek(2'd1, v); check("R5 cells unchanged", v, d);
      peek(2'd2, v); check("R5 in flag unchanged", v[1], 0);
   endtask

   task automatic t_other_addr(input logic [W-1:0] d);
      logic [W-1:0] v;
      master_write(2'd2, 8'hFF);
      master_write(2'd1, 8'h11);
      master_write(2'd3, 8'h22);
      peek(2'd0, v); check("R9 outbound unchanged", v, d);
      peek(2'd2, v); check("R9 out flag unchanged", v[0], 0);
      peek(2'd3, v); check("R9 spare reads zero", v, 0);
   endtask

   initial begin
      t_reset();
      t_master_write(8'hA5);
      t_slave_read(8'hA5);
      t_master_write(8'h3C);
      t_read_no_cs();
      t_slave_read(8'h3C);
      t_slave_write(8'h5A);
      t_master_read_clear(8'h5A);
      t_write_no_cs(8'h5A);
      t_other_addr(8'h3C);
      t_slave_write(8'hC3);
      t_master_read_clear(8'hC3);
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule